// File: doc/BRIEF.md
# Monochrome Display Region Update Streamer

This block copies a rectangle of a one-bit-per-pixel frame buffer to a small monochrome panel controller. The frame buffer is row-major: every row takes ceil(PANEL_W/8) bytes, and column j of a row is bit (j mod 8) of byte j/8, with the least significant bit first. The panel controller stores pixels as 8-row pages holding one byte per column. For each group of eight columns, the block reads eight row bytes from a synchronous RAM port with one cycle of read latency. It transposes them into column bytes and sends those bytes out on a valid/ready byte stream. A flag marks each byte as command or pixel data.

Two addressing protocols are supported. Windowed mode programs a column range and a page range once, then streams every page. The block remembers the last ranges it sent and leaves out a range command that would repeat them. Page mode sends a three-byte start position before each page. A clear request sends the whole panel with all-zero pixels and reads no RAM.

Back-pressure rules: `m_valid` never depends on `m_ready`. While `m_valid` is high and `m_ready` is low, `m_data` and `m_dc` hold their values. A byte is consumed on a rising edge where both signals are high. The sink may hold `m_ready` low for any number of cycles.

Top module: `mono_region_streamer`

## Requirements
- R1: Data byte bit k for region column c of region page p is the frame buffer pixel at row 8*(top+p)+k, column x+c. Source pixel column j is bit (j mod 8) of byte j/8 of its row, and each row is ceil(PANEL_W/8) bytes long.
- R2: The first row sent is y0 rounded down to a multiple of 8. The row end y1 (exclusive) is rounded up to a multiple of 8 and limited to PANEL_H. The page count is the span divided by 8, rounded up.
- R3: In windowed mode the output is 0x21, column start, column end (start+w-1), then 0x22, page start, page end (start+pages-1), then w*pages data bytes, page by page and left to right within a page.
- R4: A windowed range triple whose start and end both equal the values last sent for that range is left out. Reset forgets both ranges. Page-mode operations do not change the remembered ranges.
- R5: In page mode each page is preceded by the commands 0xB0|page[2:0], 0x00|col[3:0], 0x10|col[7:4], followed by exactly w data bytes.
- R6: COL_OFFSET is added to every column address byte and PAGE_OFFSET to every page address byte (defaults 0 and 1).
- R7: Rows at or beyond PANEL_H in the last page read as 0 in every data byte.
- R8: With clear set, the region is the full panel (x=0, w=PANEL_W, all pages) and every data byte is 0x00.
- R9: m_dc is 0 on command bytes and 1 on data bytes. A byte presented with m_ready low stays unchanged until it is accepted.
- R10: done is high for exactly one cycle, starting the cycle after the last byte is accepted, and m_valid is low during it. A start request while busy is ignored.
- R11: After reset, m_valid, done, busy and ram_rd are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| clear | input | 1 | Send full panel with zero pixels |
| page_mode | input | 1 | 1: per-page start protocol, 0: windowed ranges |
| reg_x | input | XW | Region left column |
| reg_w | input | XW | Region width in columns, at least 1 |
| reg_y0 | input | YW | Region top row |
| reg_y1 | input | YW | Region bottom row, exclusive |
| ram_rd | output | 1 | Frame buffer read strobe |
| ram_addr | output | AW | Byte address row*pitch+column/8 |
| ram_rdata | input | 8 | Read data, one cycle after ram_rd |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Sink accepts byte |
| m_dc | output | 1 | 0 command, 1 data |
| m_data | output | 8 | Output byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first command byte appears the cycle after the start edge, or the first data byte appears ten cycles after it when there are no commands. Each eight-column group waits nine cycles for its row fetch before its bytes appear. done rises in the cycle that follows the rising edge that consumed the last byte. The bench therefore does not predict cycle numbers for bytes. At every falling edge it compares each handshaken byte, in order, with a list computed from the requirements. It checks that a stalled byte is unchanged at the next falling edge, and that done is high at one falling edge and low at the next.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_FETCH, ST_EMIT, ST_DONE} mrs_state_t;
  localparam logic [7:0] OP_COL_RANGE  = 8'h21;
  localparam logic [7:0] OP_PAGE_RANGE = 8'h22;
  localparam logic [7:0] OP_PAGE_SEL   = 8'hB0;
  localparam logic [7:0] OP_COL_LO     = 8'h00;
  localparam logic [7:0] OP_COL_HI     = 8'h10;
  localparam int         CMD_SLOTS     = 6;
endpackage

// File: rtl/mrs_geom.sv
module mrs_geom #(
  parameter int PANEL_W = 128,
  parameter int PANEL_H = 64,
  parameter int XW = 8,
  parameter int YW = 7,
  parameter int PGW = 4
)(
  input  logic           clear,
  input  logic [XW-1:0]  rx,
  input  logic [XW-1:0]  rw,
  input  logic [YW-1:0]  ry0,
  input  logic [YW-1:0]  ry1,
  output logic [XW-1:0]  gx,
  output logic [XW-1:0]  gw,
  output logic [PGW-1:0] gtop,
  output logic [PGW-1:0] gpages
);
  localparam int ALL_PAGES = (PANEL_H + 7) / 8;
  int top_pg, bot_row;

  always_comb begin
    top_pg  = int'(ry0) / 8;
    bot_row = ((int'(ry1) + 7) / 8) * 8;
    if (bot_row > PANEL_H) bot_row = PANEL_H;
    if (clear) begin
      gx     = '0;
      gw     = XW'(PANEL_W);
      gtop   = '0;
      gpages = PGW'(ALL_PAGES);
    end else begin
      gx     = rx;
      gw     = rw;
      gtop   = PGW'(top_pg);
      gpages = PGW'((bot_row - top_pg * 8 + 7) / 8);
    end
  end
endmodule

// File: rtl/mrs_cmdgen.sv
module mrs_cmdgen import mrs_pkg::*; (
  input  logic                          page_mode,
  input  logic [7:0]                    col_s,
  input  logic [7:0]                    col_e,
  input  logic [7:0]                    pg_s,
  input  logic [7:0]                    pg_e,
  input  logic [2:0]                    pg_lo,
  input  logic                          col_hit,
  input  logic                          pg_hit,
  output logic [CMD_SLOTS-1:0][7:0]     cmd,
  output logic [2:0]                    cmd_n
);
  int k;
  always_comb begin
    cmd = '0;
    k   = 0;
    if (page_mode) begin
      cmd[0] = OP_PAGE_SEL | {5'b0, pg_lo};
      cmd[1] = OP_COL_LO   | {4'b0, col_s[3:0]};
      cmd[2] = OP_COL_HI   | {4'b0, col_s[7:4]};
      k = 3;
    end else begin
      if (!col_hit) begin
        cmd[k]   = OP_COL_RANGE;
        cmd[k+1] = col_s;
        cmd[k+2] = col_e;
        k = k + 3;
      end
      if (!pg_hit) begin
        cmd[k]   = OP_PAGE_RANGE;
        cmd[k+1] = pg_s;
        cmd[k+2] = pg_e;
        k = k + 3;
      end
    end
    cmd_n = 3'(k);
  end
endmodule

// File: rtl/mrs_xpose.sv
module mrs_xpose (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [2:0] wr_row,
  input  logic [7:0] wr_data,
  input  logic [2:0] bit_sel,
  output logic [7:0] col_byte
);
  logic [7:0][7:0] rows;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rows <= '0;
    else if (clr)    rows <= '0;
    else if (wr_en)  rows[wr_row] <= wr_data;
  end

  for (genvar r = 0; r < 8; r++) begin : g_row
    assign col_byte[r] = rows[r][bit_sel];
  end
endmodule

// File: rtl/mono_region_streamer.sv
module mono_region_streamer import mrs_pkg::*; #(
  parameter int PANEL_W     = 128,
  parameter int PANEL_H     = 64,
  parameter int COL_OFFSET  = 0,
  parameter int PAGE_OFFSET = 1,
  localparam int XW    = $clog2(PANEL_W + 1),
  localparam int YW    = $clog2(PANEL_H + 8),
  localparam int PGW   = $clog2(PANEL_H / 8 + 2),
  localparam int PITCH = (PANEL_W + 7) / 8,
  localparam int AW    = $clog2(PITCH * PANEL_H)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clear,
  input  logic          page_mode,
  input  logic [XW-1:0] reg_x,
  input  logic [XW-1:0] reg_w,
  input  logic [YW-1:0] reg_y0,
  input  logic [YW-1:0] reg_y1,
  output logic          ram_rd,
  output logic [AW-1:0] ram_addr,
  input  logic [7:0]    ram_rdata,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_dc,
  output logic [7:0]    m_data,
  output logic          busy,
  output logic          done
);
  mrs_state_t st;
  logic [XW-1:0]  x_q, w_q, col;
  logic [PGW-1:0] top_q, pages_q, pg;
  logic           clr_q, pm_q;
  logic [3:0]     fcnt;
  logic [CMD_SLOTS-1:0][7:0] cmd_q, cmd_c;
  logic [2:0]     cn_q, ci, cmd_n;
  logic           lc_v, lp_v;
  logic [7:0]     lc_s, lc_e, lp_s, lp_e;
  logic           rd_q;
  logic [2:0]     rrow_q;
  logic [7:0]     col_byte;

  logic [XW-1:0]  g_x, g_w, cur_x, cur_w;
  logic [PGW-1:0] g_top, g_pages, cur_top, cur_pages, pg_next;
  logic [7:0]     col_s, col_e, pg_s, pg_e;
  logic [2:0]     pg_lo, bit_sel;
  logic           idle, cur_pm, col_hit, pg_hit, row_ok, grp_end, last_col, last_pg;
  int             row_i, byte_i;

  mrs_geom #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .XW(XW), .YW(YW), .PGW(PGW)) i_geom (
    .clear(clear), .rx(reg_x), .rw(reg_w), .ry0(reg_y0), .ry1(reg_y1),
    .gx(g_x), .gw(g_w), .gtop(g_top), .gpages(g_pages)
  );

  // geometry source: live inputs while idle, latched values otherwise
  assign idle      = (st == ST_IDLE);
  assign cur_x     = idle ? g_x     : x_q;
  assign cur_w     = idle ? g_w     : w_q;
  assign cur_top   = idle ? g_top   : top_q;
  assign cur_pages = idle ? g_pages : pages_q;
  assign cur_pm    = idle ? page_mode : pm_q;
  assign pg_next   = idle ? '0 : PGW'(pg + 1'b1);

  assign col_s = 8'(COL_OFFSET + int'(cur_x));
  assign col_e = 8'(COL_OFFSET + int'(cur_x) + int'(cur_w) - 1);
  assign pg_s  = 8'(PAGE_OFFSET + int'(cur_top));
  assign pg_e  = 8'(PAGE_OFFSET + int'(cur_top) + int'(cur_pages) - 1);
  assign pg_lo = 3'(PAGE_OFFSET + int'(cur_top) + int'(pg_next));

  assign col_hit = lc_v && (lc_s == col_s) && (lc_e == col_e);
  assign pg_hit  = lp_v && (lp_s == pg_s) && (lp_e == pg_e);

  mrs_cmdgen i_cmdgen (
    .page_mode(cur_pm), .col_s(col_s), .col_e(col_e), .pg_s(pg_s), .pg_e(pg_e),
    .pg_lo(pg_lo), .col_hit(col_hit), .pg_hit(pg_hit), .cmd(cmd_c), .cmd_n(cmd_n)
  );

  // fetch addressing: eight rows of the byte holding the current column
  assign row_i    = (int'(top_q) + int'(pg)) * 8 + int'(fcnt[2:0]);
  assign byte_i   = (int'(x_q) + int'(col)) / 8;
  assign row_ok   = row_i < PANEL_H;
  assign ram_addr = AW'(row_i * PITCH + byte_i);
  assign ram_rd   = (st == ST_FETCH) && !fcnt[3] && !clr_q && row_ok;

  assign bit_sel  = 3'(int'(x_q) + int'(col));
  assign grp_end  = (3'(int'(x_q) + int'(col) + 1) == 3'd0);
  assign last_col = (col == XW'(int'(w_q) - 1));
  assign last_pg  = (pg == PGW'(int'(pages_q) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rrow_q <= '0;
    end else begin
      rd_q   <= ram_rd;
      rrow_q <= fcnt[2:0];
    end
  end

  mrs_xpose i_xpose (
    .clk(clk), .rst_n(rst_n), .clr((st == ST_FETCH) && (fcnt == 4'd0)),
    .wr_en(rd_q), .wr_row(rrow_q), .wr_data(ram_rdata),
    .bit_sel(bit_sel), .col_byte(col_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      x_q <= '0; w_q <= '0; col <= '0;
      top_q <= '0; pages_q <= '0; pg <= '0;
      clr_q <= 1'b0; pm_q <= 1'b0;
      fcnt <= '0; cmd_q <= '0; cn_q <= '0; ci <= '0;
      lc_v <= 1'b0; lp_v <= 1'b0;
      lc_s <= '0; lc_e <= '0; lp_s <= '0; lp_e <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          x_q <= g_x; w_q <= g_w; top_q <= g_top; pages_q <= g_pages;
          clr_q <= clear; pm_q <= page_mode;
          pg <= '0; col <= '0; ci <= '0; fcnt <= '0;
          cmd_q <= cmd_c; cn_q <= cmd_n;
          if (!page_mode) begin
            lc_v <= 1'b1; lc_s <= col_s; lc_e <= col_e;
            lp_v <= 1'b1; lp_s <= pg_s;  lp_e <= pg_e;
          end
          st <= (cmd_n == 3'd0) ? ST_FETCH : ST_CMD;
        end
        ST_CMD: if (m_ready) begin
          if (ci == cn_q - 3'd1) begin
            ci <= '0;
            st <= ST_FETCH;
          end else begin
            ci <= ci + 3'd1;
          end
        end
        ST_FETCH: begin
          if (fcnt == 4'd8) begin
            fcnt <= '0;
            st   <= ST_EMIT;
          end else begin
            fcnt <= fcnt + 4'd1;
          end
        end
        ST_EMIT: if (m_ready) begin
          if (last_col) begin
            col <= '0;
            if (last_pg) begin
              st <= ST_DONE;
            end else begin
              pg <= pg + 1'b1;
              if (pm_q) begin
                cmd_q <= cmd_c; cn_q <= cmd_n; ci <= '0;
                st <= ST_CMD;
              end else begin
                st <= ST_FETCH;
              end
            end
          end else begin
            col <= col + 1'b1;
            if (grp_end) st <= ST_FETCH;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign m_valid = (st == ST_CMD) || (st == ST_EMIT);
  assign m_dc    = (st == ST_EMIT);
  assign m_data  = (st == ST_CMD) ? cmd_q[ci] : (st == ST_EMIT) ? col_byte : 8'h00;
  assign busy    = !idle;
  assign done    = (st == ST_DONE);
endmodule

// File: rtl/mrs_chk.sv
module mrs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       m_valid,
  input logic       m_ready,
  input logic       m_dc,
  input logic [7:0] m_data,
  input logic       busy,
  input logic       done,
  input logic       ram_rd
);
  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_dc));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_valid && busy);
  // R9
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> busy);
  // R1
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |-> !m_valid && busy);
endmodule

bind mono_region_streamer mrs_chk i_mrs_chk (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_dc(m_dc),
  .m_data(m_data), .busy(busy), .done(done), .ram_rd(ram_rd)
);

// File: tb/test_mono_region_streamer.sv
`timescale 1ns/1ps
module test_mono_region_streamer;
  localparam int W = 100, H = 60, CO = 2, PO = 1;
  localparam int XW = $clog2(W + 1), YW = $clog2(H + 8);
  localparam int PITCH = (W + 7) / 8, AW = $clog2(PITCH * H);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, clear_i = 1'b0, pm_i = 1'b0, m_ready = 1'b0;
  logic [XW-1:0] reg_x = '0, reg_w = '0;
  logic [YW-1:0] reg_y0 = '0, reg_y1 = '0;
  logic ram_rd, m_valid, m_dc, busy, done;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_rdata = 8'h00, m_data;
  logic [7:0] mem [0:PITCH*H-1];

  int n_chk = 0, n_fail = 0;
  logic [8:0] exp_q [$];
  bit e_lcv = 0, e_lpv = 0;
  logic [7:0] e_lcs, e_lce, e_lps, e_lpe;

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr];

  mono_region_streamer #(.PANEL_W(W), .PANEL_H(H), .COL_OFFSET(CO), .PAGE_OFFSET(PO)) i_mono_region_streamer (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear_i), .page_mode(pm_i),
    .reg_x(reg_x), .reg_w(reg_w), .reg_y0(reg_y0), .reg_y1(reg_y1),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_dc(m_dc), .m_data(m_data),
    .busy(busy), .done(done)
  );

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(bit dc, int v);
    exp_q.push_back({dc, 8'(v)});
  endtask

  // expected stream from the requirements (R1..R8)
  task automatic build(bit clr, bit pm, int x, int w, int y0, int y1);
    int top, bot, pages, cs, ce, ps, pe;
    exp_q.delete();
    if (clr) begin x = 0; w = W; top = 0; pages = (H + 7) / 8; end
    else begin
      top = y0 / 8; bot = ((y1 + 7) / 8) * 8;
      if (bot > H) bot = H;
      pages = (bot - top * 8 + 7) / 8;
    end
    cs = (CO + x) & 255; ce = (CO + x + w - 1) & 255;
    ps = (PO + top) & 255; pe = (PO + top + pages - 1) & 255;
    if (!pm) begin
      if (!(e_lcv && e_lcs == 8'(cs) && e_lce == 8'(ce))) begin push(0, 8'h21); push(0, cs); push(0, ce); end
      if (!(e_lpv && e_lps == 8'(ps) && e_lpe == 8'(pe))) begin push(0, 8'h22); push(0, ps); push(0, pe); end
      e_lcv = 1; e_lcs = 8'(cs); e_lce = 8'(ce);
      e_lpv = 1; e_lps = 8'(ps); e_lpe = 8'(pe);
    end
    for (int p = 0; p < pages; p++) begin
      if (pm) begin
        push(0, 8'hB0 | ((PO + top + p) & 7));
        push(0, cs & 15);
        push(0, 8'h10 | ((cs >> 4) & 15));
      end
      for (int c = 0; c < w; c++) begin
        int b = 0;
        for (int k = 0; k < 8; k++) begin
          int row = 8 * (top + p) + k;
          if (row < H && !clr) b |= ((mem[row * PITCH + (x + c) / 8] >> ((x + c) % 8)) & 1) << k;
        end
        push(1, b);
      end
    end
  endtask

  task automatic run_op(string tag, bit clr, bit pm, int x, int w, int y0, int y1, bit poke);
    int idx = 0, cyc = 0;
    bit seen = 0, pv = 0, r;
    logic [7:0] pd = 0;
    logic pdc = 0;
    build(clr, pm, x, w, y0, y1);
    clear_i = clr; pm_i = pm;
    reg_x = XW'(x); reg_w = XW'(w); reg_y0 = YW'(y0); reg_y1 = YW'(y1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen && cyc < 30000) begin
      if (poke && cyc == 4) begin
        start = 1'b1; clear_i = ~clr; pm_i = ~pm; reg_x = '0; reg_w = XW'(1);
      end else if (poke && cyc == 5) start = 1'b0;
      if (pv) chk(m_valid && m_data == pd && m_dc == pdc, "R9", "stalled byte changed",
                  {m_valid, m_dc, m_data}, {1'b1, pdc, pd});
      if (done) begin
        seen = 1;
        chk(idx == exp_q.size(), tag, "byte count at done (R10)", idx, exp_q.size());
        chk(!m_valid, "R10", "valid during done", m_valid, 0);
      end else begin
        r = ($urandom % 4) != 0;
        m_ready = r;
        if (m_valid && r) begin
          if (idx < exp_q.size())
            chk({m_dc, m_data} == exp_q[idx], tag, $sformatf("byte %0d {dc,data}", idx),
                {m_dc, m_data}, exp_q[idx]);
          else
            chk(0, tag, "extra byte", {m_dc, m_data}, 0);
          idx++;
        end
        pv = m_valid && !r; pd = m_data; pdc = m_dc;
      end
      @(negedge clk);
      cyc++;
    end
    m_ready = 1'b0;
    if (!seen) chk(0, tag, "watchdog: no done", idx, exp_q.size());
    else begin
      chk(!done, "R10", "done longer than one cycle", done, 0);
      chk(!busy, "R10", "busy after done", busy, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < PITCH * H; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!m_valid && !done && !busy && !ram_rd, "R11", "outputs in reset",
        {m_valid, done, busy, ram_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_valid && !done && !busy && !ram_rd, "R11", "outputs after reset",
        {m_valid, done, busy, ram_rd}, 0);
    // R1 R2 R3 R6: windowed, unaligned column and row edges
    run_op("R3", 0, 0, 3, 20, 5, 17, 0);
    // R4: identical region, both ranges suppressed
    run_op("R4", 0, 0, 3, 20, 0, 23, 0);
    // R4: only column range repeats
    run_op("R4", 0, 0, 3, 20, 24, 30, 0);
    // R5 R6: page mode, plus ignored start while busy (R10)
    run_op("R5", 0, 1, 10, 30, 0, 24, 1);
    // R4: page mode left ranges untouched, so no commands
    run_op("R4", 0, 0, 3, 20, 24, 30, 0);
    // R7 R2: last page partial, bottom clamped
    run_op("R7", 0, 0, 40, 17, 50, 58, 0);
    run_op("R7", 0, 1, 0, 9, 49, 60, 0);
    // R8 clear in both protocols
    run_op("R8", 1, 0, 0, 1, 0, 1, 0);
    run_op("R8", 1, 1, 0, 1, 0, 1, 0);
    // R1 corner: last column only, single row
    run_op("R1", 0, 0, W - 1, 1, 7, 8, 0);
    run_op("R1", 0, 1, 0, W, 8, 9, 0);
    // random regions
    for (int i = 0; i < 14; i++) begin
      int x = $urandom % W;
      int w = 1 + $urandom % (W - x);
      int y0 = $urandom % H;
      int y1 = y0 + 1 + $urandom % (H - y0);
      run_op("R1", ($urandom % 8) == 0, $urandom % 2, x, w, y0, y1, ($urandom % 4) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule